// File: doc/BRIEF.md
# Rational Edge-Preserving Pixel Filter Datapath

This block computes one smoothed output pixel per input window. The window holds a centre pixel and, for each filtering direction, two opposite neighbour pixels. The neighbours may come from the same frame (spatial use) or from the previous and next frames at the same position (temporal use). For each direction, a three-tap linear filter combines the two neighbours with the centre. The filter result is then scaled by a weight in the range 0 to 1. That weight comes from a small staircase table, indexed by the absolute difference of the two neighbours, so strong edges get only a small correction. The weighted terms of all directions are added together, rounded, and added to a base value. The sum is then clamped to the pixel range.

The base value is chosen by an output mode. It can be the centre pixel, the block's own previous output (for repeated passes that add more directions or taps), or a value from a cascade port (for chaining several instances). Filter coefficients and weight tables are stored in several sets, and an external noise-type code picks the active set. Software-free loading of these sets goes through a simple write port. Building the window and reaching frame memory are left to the surrounding logic.

Top module: `nr_rational_filter`

## Requirements
- R1: After reset, `outValid` is 0, `outPix` is 0, every coefficient of every set is 0, and every weight table of every set and direction holds the codes 63, 52, 42, 31, 20, 12, 5, 1 for bins 0 to 7.
- R2: The block can accept a window on every clock edge where `inValid` is 1. The result of a window sampled at edge n is on `outPix`, with `outValid` high for exactly one cycle, after edge n+3.
- R3: For direction d, the neighbour pixels are `sideAPix[8d+7:8d]` (A) and `sideBPix[8d+7:8d]` (B), and C is the centre pixel. The linear term is cA·A + cC·C + cB·B. Coefficients are signed 6-bit values with 5 fractional bits. Tap index 0 is cA, 1 is cC and 2 is cB.
- R4: The weight bin for a direction is the largest k for which |A−B| is at least the k-th lower bound of 0, 8, 16, 24, 32, 48, 64, 128 (k counted from 0).
- R5: A stored 6-bit weight code w stands for a weight of (w+1)/64.
- R6: The weighted terms of all directions are summed exactly in units of 2^-11. The sum is rounded to an integer by adding 1024 and shifting right arithmetically by 11, so ties round toward +∞.
- R7: The output is the base plus the rounded sum, clamped to the range 0 to 255.
- R8: `outMode` sets the base. 00 gives the centre pixel, 01 gives the previous output, 10 gives `cascadeIn`, and 11 behaves like 00.
- R9: In mode 01 the base is the most recent value on `outPix`, which is the result of the immediately preceding window even when windows arrive back to back.
- R10: `noiseCode` values 0 to 5 select coefficient and table set 0 to 5. Codes 6 and 7 select set 0.
- R11: A write with `cfgWe` stores `cfgData` at `cfgAddr`. The address fields are: bit 9 chooses a coefficient (0) or a table word (1), bits 8:6 give the set, bits 5:3 give the direction, and bits 2:0 give the tap or bin. A write is ignored if the set is 6 or more, the direction is 5 or more, or it targets coefficient tap 3 or above.
- R12: While `outValid` is 0, `outPix` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | 10 | Configuration address (kind, set, direction, index) |
| cfgData | input | 6 | Coefficient or weight code to store |
| noiseCode | input | 3 | Noise-type code selecting the parameter set |
| outMode | input | 2 | Base selection: centre, previous output, cascade |
| inValid | input | 1 | Window present on the pixel inputs |
| centrePix | input | 8 | Centre pixel |
| sideAPix | input | 40 | First neighbour of each direction, 8 bits per direction |
| sideBPix | input | 40 | Opposite neighbour of each direction, 8 bits per direction |
| cascadeIn | input | 8 | Base value from a preceding stage |
| outValid | output | 1 | Result valid pulse |
| outPix | output | 8 | Filtered pixel |

## Verification
The bench builds the block with five directions and six parameter sets, which are the defaults. With these values the 3-bit set and direction fields of the write address can hold values beyond the stored range: sets 6 and 7, and directions 5 to 7. The same applies to noise codes 6 and 7. The ignored-write and fallback-set rules can therefore be exercised through the ports. With five directions, all-maximum coefficients drive the sum well past both clamp limits. A single active direction can also be set up to land the sum exactly on a rounding tie.

// File: rtl/nr_pkg.sv
package nr_pkg;
  localparam int COEF_W = 6;
  localparam int WGT_W = 6;
  localparam int TAPS = 3;
  localparam int NBINS = 8;
  localparam int BIN_W = $clog2(NBINS);
  localparam int SET_W = 3;
  localparam int DIR_W = 3;
  localparam int IDX_W = 3;
  localparam int CFG_ADDR_W = 1 + SET_W + DIR_W + IDX_W;

  // lower bounds of the absolute-difference bins
  localparam int BIN_LO [NBINS] = '{0, 8, 16, 24, 32, 48, 64, 128};
  // codes loaded at reset; weight = (code + 1) / 64
  localparam int RESET_CODE [NBINS] = '{63, 52, 42, 31, 20, 12, 5, 1};

  typedef enum logic [1:0] {
    MODE_BASIC = 2'b00,
    MODE_ITER  = 2'b01,
    MODE_CASC  = 2'b10,
    MODE_ALT   = 2'b11
  } outMode_e;

  typedef struct packed {
    logic s1;
    logic s2;
    logic s3;
    logic s4;
  } strobes_t;

  typedef struct packed {
    logic              coefWe;
    logic              lutWe;
    logic [SET_W-1:0]  set;
    logic [DIR_W-1:0]  dir;
    logic [IDX_W-1:0]  idx;
    logic [COEF_W-1:0] data;
  } cfgWrite_t;
endpackage

// File: rtl/nr_ctrl.sv
module nr_ctrl
  import nr_pkg::*;
#(
  parameter int NUM_DIR  = 5,
  parameter int NUM_SETS = 6
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  inValid,
  input  logic                  cfgWe,
  input  logic [CFG_ADDR_W-1:0] cfgAddr,
  input  logic [COEF_W-1:0]     cfgData,
  output strobes_t              strb,
  output cfgWrite_t             cfgWr
);
  localparam int IDX_LSB = 0;
  localparam int DIR_LSB = IDX_W;
  localparam int SET_LSB = IDX_W + DIR_W;
  localparam int KIND_BIT = CFG_ADDR_W - 1;

  logic v1, v2, v3;
  logic [SET_W-1:0] fSet;
  logic [DIR_W-1:0] fDir;
  logic [IDX_W-1:0] fIdx;
  logic inRange;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
      v3 <= 1'b0;
    end else begin
      v1 <= inValid;
      v2 <= v1;
      v3 <= v2;
    end
  end

  always_comb begin
    strb.s1 = inValid;
    strb.s2 = v1;
    strb.s3 = v2;
    strb.s4 = v3;
  end

  always_comb begin
    fSet = cfgAddr[SET_LSB +: SET_W];
    fDir = cfgAddr[DIR_LSB +: DIR_W];
    fIdx = cfgAddr[IDX_LSB +: IDX_W];
    inRange = (int'(fSet) < NUM_SETS) && (int'(fDir) < NUM_DIR);
    cfgWr.set = fSet;
    cfgWr.dir = fDir;
    cfgWr.idx = fIdx;
    cfgWr.data = cfgData;
    cfgWr.coefWe = cfgWe && !cfgAddr[KIND_BIT] && inRange && (int'(fIdx) < TAPS);
    cfgWr.lutWe = cfgWe && cfgAddr[KIND_BIT] && inRange;
  end
endmodule

// File: rtl/nr_cfg_bank.sv
module nr_cfg_bank
  import nr_pkg::*;
#(
  parameter int NUM_DIR  = 5,
  parameter int NUM_SETS = 6
) (
  input  logic                                         clk,
  input  logic                                         rstN,
  input  cfgWrite_t                                    cfgWr,
  input  logic [SET_W-1:0]                             coefSetIdx,
  input  logic [SET_W-1:0]                             lutSetIdx,
  output logic [NUM_DIR-1:0][TAPS-1:0][COEF_W-1:0]     coefSel,
  output logic [NUM_DIR-1:0][NBINS-1:0][WGT_W-1:0]     lutSel
);
  logic [COEF_W-1:0] coefR [NUM_SETS][NUM_DIR][TAPS];
  logic [WGT_W-1:0]  lutR  [NUM_SETS][NUM_DIR][NBINS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < NUM_SETS; s++)
        for (int d = 0; d < NUM_DIR; d++) begin
          for (int t = 0; t < TAPS; t++) coefR[s][d][t] <= '0;
          for (int b = 0; b < NBINS; b++) lutR[s][d][b] <= WGT_W'(RESET_CODE[b]);
        end
    end else begin
      for (int s = 0; s < NUM_SETS; s++)
        for (int d = 0; d < NUM_DIR; d++) begin
          for (int t = 0; t < TAPS; t++)
            if (cfgWr.coefWe && int'(cfgWr.set) == s && int'(cfgWr.dir) == d &&
                int'(cfgWr.idx) == t)
              coefR[s][d][t] <= cfgWr.data;
          for (int b = 0; b < NBINS; b++)
            if (cfgWr.lutWe && int'(cfgWr.set) == s && int'(cfgWr.dir) == d &&
                int'(cfgWr.idx) == b)
              lutR[s][d][b] <= cfgWr.data;
        end
    end
  end

  always_comb begin
    coefSel = '0;
    lutSel = '0;
    for (int s = 0; s < NUM_SETS; s++)
      for (int d = 0; d < NUM_DIR; d++) begin
        if (int'(coefSetIdx) == s)
          for (int t = 0; t < TAPS; t++) coefSel[d][t] = coefR[s][d][t];
        if (int'(lutSetIdx) == s)
          for (int b = 0; b < NBINS; b++) lutSel[d][b] = lutR[s][d][b];
      end
  end
endmodule

// File: rtl/nr_datapath.sv
module nr_datapath
  import nr_pkg::*;
#(
  parameter int NUM_DIR  = 5,
  parameter int PIX_W    = 8,
  parameter int NUM_SETS = 6
) (
  input  logic                                      clk,
  input  logic                                      rstN,
  input  strobes_t                                  strb,
  input  logic [SET_W-1:0]                          noiseCode,
  input  logic [1:0]                                outMode,
  input  logic [PIX_W-1:0]                          centrePix,
  input  logic [NUM_DIR*PIX_W-1:0]                  sideAPix,
  input  logic [NUM_DIR*PIX_W-1:0]                  sideBPix,
  input  logic [PIX_W-1:0]                          cascadeIn,
  input  logic [NUM_DIR-1:0][TAPS-1:0][COEF_W-1:0]  coefIn,
  input  logic [NUM_DIR-1:0][NBINS-1:0][WGT_W-1:0]  lutIn,
  output logic [SET_W-1:0]                          coefSetIdx,
  output logic [SET_W-1:0]                          lutSetIdx,
  output logic                                      outValid,
  output logic [PIX_W-1:0]                          outPix
);
  localparam int LF_W   = PIX_W + COEF_W + 3;
  localparam int WT_W   = WGT_W + 2;
  localparam int WP_W   = LF_W + WT_W;
  localparam int SUM_W  = WP_W + $clog2(NUM_DIR) + 1;
  localparam int FRAC_W = (COEF_W - 1) + WGT_W;
  localparam int TOT_W  = SUM_W + 1;
  localparam int PIX_MAX = (1 << PIX_W) - 1;
  localparam logic signed [SUM_W-1:0] HALF = SUM_W'(2 ** (FRAC_W - 1));

  function automatic logic [BIN_W-1:0] binOf(input logic [PIX_W-1:0] ad);
    logic [BIN_W-1:0] b;
    b = '0;
    for (int k = 1; k < NBINS; k++)
      if (int'(ad) >= BIN_LO[k]) b = BIN_W'(k);
    return b;
  endfunction

  // stage registers shared by all directions
  logic [SET_W-1:0] set1;
  logic [PIX_W-1:0] c1, c2, c3, k1, k2, k3;
  outMode_e m1, m2, m3;
  logic signed [SUM_W-1:0] rnd3;

  logic signed [LF_W-1:0] lf1 [NUM_DIR];
  logic [BIN_W-1:0]       bin1 [NUM_DIR];
  logic signed [WP_W-1:0] wp2 [NUM_DIR];

  assign coefSetIdx = (int'(noiseCode) < NUM_SETS) ? noiseCode : '0;
  assign lutSetIdx = set1;

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
    logic [PIX_W-1:0] pa, pb, ad;
    logic signed [LF_W-1:0] xa, xb, xc, ca, cc, cb, lfNext;
    logic [WGT_W-1:0] code;
    logic signed [WP_W-1:0] wgt;

    assign pa = sideAPix[d*PIX_W +: PIX_W];
    assign pb = sideBPix[d*PIX_W +: PIX_W];
    assign ad = (pa > pb) ? (pa - pb) : (pb - pa);
    assign xa = LF_W'($signed({1'b0, pa}));
    assign xb = LF_W'($signed({1'b0, pb}));
    assign xc = LF_W'($signed({1'b0, centrePix}));
    assign ca = LF_W'($signed(coefIn[d][0]));
    assign cc = LF_W'($signed(coefIn[d][1]));
    assign cb = LF_W'($signed(coefIn[d][2]));
    assign lfNext = xa * ca + xc * cc + xb * cb;

    assign code = lutIn[d][bin1[d]];
    assign wgt = $signed(WP_W'({1'b0, code})) + WP_W'(1);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        lf1[d] <= '0;
        bin1[d] <= '0;
        wp2[d] <= '0;
      end else begin
        if (strb.s1) begin
          lf1[d] <= lfNext;
          bin1[d] <= binOf(ad);
        end
        if (strb.s2) wp2[d] <= WP_W'(lf1[d]) * wgt;
      end
    end
  end

  logic signed [SUM_W-1:0] acc, rndNext;
  always_comb begin
    acc = '0;
    for (int d = 0; d < NUM_DIR; d++) acc = acc + SUM_W'(wp2[d]);
    rndNext = (acc + HALF) >>> FRAC_W;
  end

  logic [PIX_W-1:0] baseSel;
  logic signed [TOT_W-1:0] totNext;
  logic [PIX_W-1:0] satNext;
  always_comb begin
    unique case (m3)
      MODE_ITER: baseSel = outPix;
      MODE_CASC: baseSel = k3;
      default:   baseSel = c3;
    endcase
    totNext = TOT_W'(rnd3) + TOT_W'($signed({1'b0, baseSel}));
    if (totNext < 0) satNext = '0;
    else if (totNext > TOT_W'(PIX_MAX)) satNext = PIX_W'(PIX_MAX);
    else satNext = totNext[PIX_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      set1 <= '0;
      c1 <= '0; c2 <= '0; c3 <= '0;
      k1 <= '0; k2 <= '0; k3 <= '0;
      m1 <= MODE_BASIC; m2 <= MODE_BASIC; m3 <= MODE_BASIC;
      rnd3 <= '0;
      outPix <= '0;
      outValid <= 1'b0;
    end else begin
      if (strb.s1) begin
        set1 <= coefSetIdx;
        c1 <= centrePix;
        k1 <= cascadeIn;
        m1 <= outMode_e'(outMode);
      end
      if (strb.s2) begin
        c2 <= c1;
        k2 <= k1;
        m2 <= m1;
      end
      if (strb.s3) begin
        c3 <= c2;
        k3 <= k2;
        m3 <= m2;
        rnd3 <= rndNext;
      end
      if (strb.s4) outPix <= satNext;
      outValid <= strb.s4;
    end
  end
endmodule

// File: rtl/nr_rational_filter.sv
module nr_rational_filter
  import nr_pkg::*;
#(
  parameter int NUM_DIR  = 5,
  parameter int PIX_W    = 8,
  parameter int NUM_SETS = 6
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     cfgWe,
  input  logic [CFG_ADDR_W-1:0]    cfgAddr,
  input  logic [COEF_W-1:0]        cfgData,
  input  logic [SET_W-1:0]         noiseCode,
  input  logic [1:0]               outMode,
  input  logic                     inValid,
  input  logic [PIX_W-1:0]         centrePix,
  input  logic [NUM_DIR*PIX_W-1:0] sideAPix,
  input  logic [NUM_DIR*PIX_W-1:0] sideBPix,
  input  logic [PIX_W-1:0]         cascadeIn,
  output logic                     outValid,
  output logic [PIX_W-1:0]         outPix
);
  strobes_t strb;
  cfgWrite_t cfgWr;
  logic [SET_W-1:0] coefSetIdx, lutSetIdx;
  logic [NUM_DIR-1:0][TAPS-1:0][COEF_W-1:0] coefSel;
  logic [NUM_DIR-1:0][NBINS-1:0][WGT_W-1:0] lutSel;

  nr_ctrl #(.NUM_DIR(NUM_DIR), .NUM_SETS(NUM_SETS)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .cfgWe(cfgWe),
    .cfgAddr(cfgAddr), .cfgData(cfgData), .strb(strb), .cfgWr(cfgWr)
  );

  nr_cfg_bank #(.NUM_DIR(NUM_DIR), .NUM_SETS(NUM_SETS)) u_bank (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .coefSetIdx(coefSetIdx),
    .lutSetIdx(lutSetIdx), .coefSel(coefSel), .lutSel(lutSel)
  );

  nr_datapath #(.NUM_DIR(NUM_DIR), .PIX_W(PIX_W), .NUM_SETS(NUM_SETS)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .noiseCode(noiseCode),
    .outMode(outMode), .centrePix(centrePix), .sideAPix(sideAPix),
    .sideBPix(sideBPix), .cascadeIn(cascadeIn), .coefIn(coefSel),
    .lutIn(lutSel), .coefSetIdx(coefSetIdx), .lutSetIdx(lutSetIdx),
    .outValid(outValid), .outPix(outPix)
  );
endmodule

// File: rtl/nr_chk.sv
module nr_chk
  import nr_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic             outValid,
  input logic [PIX_W-1:0] outPix,
  input strobes_t         strb
);
  logic [2:0] since;
  logic rstSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) since <= '0;
    else if (since != 3'd7) since <= since + 3'd1;
  end

  always_ff @(posedge clk) rstSeen <= !rstN;

  // R1
  reset_state_chk: assert property (@(posedge clk)
    (rstSeen && !rstN) |-> (!outValid && outPix == '0));

  // R2
  latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    (since >= 3'd4) |-> (outValid == $past(inValid, 4)));

  // R2
  strobe_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (since >= 3'd1) |-> (outValid == $past(strb.s4)));

  // R12
  hold_pix_chk: assert property (@(posedge clk) disable iff (!rstN)
    (since >= 3'd1 && !outValid) |-> $stable(outPix));
endmodule

bind nr_rational_filter nr_chk #(.PIX_W(PIX_W)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .outValid(outValid),
  .outPix(outPix), .strb(strb)
);

// File: tb/sim_nr_rational_filter.sv
`timescale 1ns/1ps
module sim_nr_rational_filter;
  localparam int ND = 5;
  localparam int PW = 8;
  localparam int NS = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWe = 1'b0;
  logic [9:0] cfgAddr = '0;
  logic [5:0] cfgData = '0;
  logic [2:0] noiseCode = '0;
  logic [1:0] outMode = '0;
  logic inValid = 1'b0;
  logic [PW-1:0] centrePix = '0;
  logic [ND*PW-1:0] sideAPix = '0;
  logic [ND*PW-1:0] sideBPix = '0;
  logic [PW-1:0] cascadeIn = '0;
  logic outValid;
  logic [PW-1:0] outPix;

  always #2.5 clk = ~clk;

  nr_rational_filter #(.NUM_DIR(ND), .PIX_W(PW), .NUM_SETS(NS)) u0 (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .noiseCode(noiseCode), .outMode(outMode), .inValid(inValid),
    .centrePix(centrePix), .sideAPix(sideAPix), .sideBPix(sideBPix),
    .cascadeIn(cascadeIn), .outValid(outValid), .outPix(outPix)
  );

  int coefM [NS][ND][3];
  int lutM [NS][ND][8];
  int resetLut [8] = '{63, 52, 42, 31, 20, 12, 5, 1};
  bit pv [3];
  int pr [3], pm [3], pc [3], pk [3];
  bit expValid;
  int expPix;
  int checks = 0, fails = 0;
  string curReq = "R1";
  bit started = 0, done = 0;

  function automatic int binM(int ad);
    int b = 0;
    if (ad >= 8) b = 1;
    if (ad >= 16) b = 2;
    if (ad >= 24) b = 3;
    if (ad >= 32) b = 4;
    if (ad >= 48) b = 5;
    if (ad >= 64) b = 6;
    if (ad >= 128) b = 7;
    return b;
  endfunction

  function automatic int partialM();
    int s = (int'(noiseCode) < NS) ? int'(noiseCode) : 0;
    int tot = 0;
    for (int d = 0; d < ND; d++) begin
      int a = int'(sideAPix[d*PW +: PW]);
      int b = int'(sideBPix[d*PW +: PW]);
      int c = int'(centrePix);
      int lf = coefM[s][d][0] * a + coefM[s][d][1] * c + coefM[s][d][2] * b;
      int ad = (a > b) ? a - b : b - a;
      tot += lf * (lutM[s][d][binM(ad)] + 1);
    end
    return (tot + 1024) >>> 11;
  endfunction

  // behavioural reference, advanced on every rising edge
  always @(posedge clk) begin : mdl
    int base;
    int t;
    if (!rstN) begin
      for (int i = 0; i < 3; i++) pv[i] = 0;
      expValid = 0;
      expPix = 0;
    end else begin
      expValid = pv[2];
      if (pv[2]) begin
        base = (pm[2] == 1) ? expPix : (pm[2] == 2) ? pk[2] : pc[2];
        t = base + pr[2];
        expPix = (t < 0) ? 0 : (t > 255) ? 255 : t;
      end
      for (int i = 2; i > 0; i--) begin
        pv[i] = pv[i-1]; pr[i] = pr[i-1]; pm[i] = pm[i-1];
        pc[i] = pc[i-1]; pk[i] = pk[i-1];
      end
      pv[0] = inValid;
      if (inValid) begin
        pr[0] = partialM();
        pm[0] = int'(outMode);
        pc[0] = int'(centrePix);
        pk[0] = int'(cascadeIn);
      end
    end
  end

  always @(negedge clk) begin
    if (started && rstN && !done) begin
      checks++;
      if (outValid !== expValid || int'(outPix) != expPix) begin
        fails++;
        $display("FAIL %s: outValid=%0d outPix=%0d expected outValid=%0d outPix=%0d",
                 curReq, outValid, outPix, expValid, expPix);
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfgW(bit kind, int s, int d, int i, int v, bit applies);
    cfgWe = 1'b1;
    cfgAddr = {kind, 3'(s), 3'(d), 3'(i)};
    cfgData = 6'(v);
    @(posedge clk);
    if (applies) begin
      if (kind) lutM[s][d][i] = v & 63;
      else coefM[s][d][i] = ((v & 63) >= 32) ? (v & 63) - 64 : (v & 63);
    end
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic win(int md, int code, int ctr, int casc);
    outMode = 2'(md);
    noiseCode = 3'(code);
    centrePix = 8'(ctr);
    cascadeIn = 8'(casc);
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic randSides();
    for (int d = 0; d < ND; d++) begin
      sideAPix[d*PW +: PW] = 8'($urandom_range(0, 255));
      sideBPix[d*PW +: PW] = 8'($urandom_range(0, 255));
    end
  endtask

  task automatic setSet0All(int v);
    for (int d = 0; d < ND; d++)
      for (int t = 0; t < 3; t++) cfgW(0, 0, d, t, v, 1);
  endtask

  initial begin
    for (int s = 0; s < NS; s++)
      for (int d = 0; d < ND; d++) begin
        for (int t = 0; t < 3; t++) coefM[s][d][t] = 0;
        for (int b = 0; b < 8; b++) lutM[s][d][b] = resetLut[b];
      end
    idle(3);
    checks++;
    if (outValid !== 1'b0 || outPix !== 8'd0) begin
      fails++;
      $display("FAIL R1: reset outValid=%0d outPix=%0d expected 0 0", outValid, outPix);
    end
    rstN = 1'b1;
    started = 1;
    idle(2);

    // R1: coefficients clear after reset, output equals centre
    curReq = "R1";
    for (int i = 0; i < 6; i++) begin
      randSides();
      win(0, $urandom_range(0, 7), $urandom_range(0, 255), 0);
    end
    idle(5);

    // R3: random signed coefficients in set 0
    curReq = "R3";
    for (int d = 0; d < ND; d++)
      for (int t = 0; t < 3; t++) cfgW(0, 0, d, t, $urandom_range(0, 63), 1);
    for (int i = 0; i < 10; i++) begin
      randSides();
      win(0, (i % 2 == 0) ? 0 : 7, $urandom_range(0, 255), 0);
    end
    idle(5);

    // R4 R5: every bin edge with reset weight codes
    curReq = "R4 R5";
    setSet0All(0);
    cfgW(0, 0, 0, 0, 10, 1);
    cfgW(0, 0, 0, 1, -20, 1);
    cfgW(0, 0, 0, 2, 10, 1);
    foreach (resetLut[k]) begin end
    for (int i = 0; i < 16; i++) begin
      int diffs [16] = '{0, 7, 8, 15, 16, 23, 24, 31, 32, 47, 48, 63, 64, 127, 128, 155};
      sideAPix = {ND{8'd128}};
      sideBPix = {ND{8'd128}};
      sideAPix[7:0] = 8'd100;
      sideBPix[7:0] = 8'(100 + diffs[i]);
      win(0, 0, 128, 0);
    end
    idle(5);

    // R6: exact ties at +1024 and -1024 units
    curReq = "R6";
    setSet0All(0);
    cfgW(0, 0, 0, 0, 1, 1);
    sideAPix = {ND{8'd16}};
    sideBPix = {ND{8'd16}};
    win(0, 0, 100, 0);
    idle(5);
    cfgW(0, 0, 0, 0, -1, 1);
    win(0, 0, 100, 0);
    idle(5);

    // R7: clamp at both ends
    curReq = "R7";
    setSet0All(31);
    sideAPix = {ND{8'd255}};
    sideBPix = {ND{8'd255}};
    win(0, 0, 255, 0);
    idle(5);
    setSet0All(32);
    win(0, 0, 255, 0);
    win(0, 0, 3, 0);
    idle(5);

    // R8 R9: base selection, back to back
    curReq = "R8 R9";
    for (int d = 0; d < ND; d++)
      for (int t = 0; t < 3; t++) cfgW(0, 0, d, t, $urandom_range(0, 15), 1);
    begin
      int modes [7] = '{0, 1, 1, 2, 3, 1, 2};
      for (int i = 0; i < 7; i++) begin
        randSides();
        win(modes[i], 0, $urandom_range(0, 255), $urandom_range(0, 255));
      end
    end
    idle(5);

    // R10: separate set 3 and fallback codes
    curReq = "R10";
    for (int d = 0; d < ND; d++) begin
      for (int t = 0; t < 3; t++) cfgW(0, 3, d, t, $urandom_range(0, 63), 1);
      for (int b = 0; b < 8; b++) cfgW(1, 3, d, b, $urandom_range(0, 63), 1);
    end
    begin
      int codes [6] = '{3, 6, 7, 0, 5, 3};
      for (int i = 0; i < 6; i++) begin
        randSides();
        win(0, codes[i], $urandom_range(0, 255), 0);
      end
    end
    idle(5);

    // R11: writes outside the stored range leave state unchanged
    curReq = "R11";
    cfgW(0, 0, 0, 3, 31, 0);
    cfgW(0, 6, 0, 0, 31, 0);
    cfgW(0, 7, 1, 1, 31, 0);
    cfgW(0, 0, 5, 0, 31, 0);
    cfgW(1, 6, 0, 0, 0, 0);
    cfgW(1, 0, 7, 2, 0, 0);
    cfgW(1, 0, 0, 7, 0, 1);
    for (int i = 0; i < 8; i++) begin
      randSides();
      win(0, (i % 3 == 0) ? 0 : (i % 3 == 1) ? 6 : 7, $urandom_range(0, 255), 0);
    end
    idle(5);

    // R2: one window per cycle
    curReq = "R2";
    for (int i = 0; i < 30; i++) begin
      randSides();
      win($urandom_range(0, 3), $urandom_range(0, 7), $urandom_range(0, 255),
          $urandom_range(0, 255));
    end
    idle(5);

    // R12: gaps between windows
    curReq = "R12";
    for (int i = 0; i < 12; i++) begin
      randSides();
      win($urandom_range(0, 3), $urandom_range(0, 7), $urandom_range(0, 255),
          $urandom_range(0, 255));
      idle($urandom_range(1, 4));
    end
    idle(8);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    #(900000);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule